// File: doc/BRIEF.md
# Clock Glitch Timing Sequencer

This block is the control core of a clock fault generator. It runs from a free-running 100 MHz reference clock. Software first loads a countdown value and a shortening step count, then arms the block. A trigger from the target device marks the start of the operation under test. The trigger is resynchronised, and only its rising edge counts. After the programmed number of reference cycles, the block raises a select pulse exactly one reference cycle wide. During that cycle an external glitch-free multiplexer swaps in a clock built from two delayed copies of the reference. The shortened cycle therefore lasts the nominal 10 ns minus the programmed number of 35 ps steps. After that pulse the block disarms itself.

The block also drives the two delay-line codes. The code for the phase that supplies the rising edge equals the step count. The code for the phase that supplies the falling edge is half of it, which keeps the faulted cycle near a 50% duty cycle. The step count is clamped so that the shortening always stays below one full period.

Configuration arrives through a valid/ready write port. The port uses back-pressure to protect the codes and the countdown from the moment the block is armed until its glitch has completed. A campaign that sweeps the shortening one step per run simply rewrites the step count and re-arms the block between runs.

Top module: `clk_glitch_seq`

## Requirements
- R1: After reset, `glitch_sel` and `armed` are 0, both codes are 0, and `cfg_ready` is 1.
- R2: A write completes at a clock edge where `cfg_valid` and `cfg_ready` are both 1. Writes to address 0 set the countdown (data bits 7:0), and writes to address 1 set the step count (data bits 8:0). Writes to address 2 arm the block when data bit 0 is 1. Writes to address 3 are accepted and ignored. A new step count shows on the code outputs in the cycle after the write.
- R3: A step count above 285 (the largest whole number of 35 ps steps below a 10 ns period) is stored as 285.
- R4: `code_fall` equals `code_rise` shifted right by one bit, rounding down. `code_rise` equals the stored step count.
- R5: `cfg_ready` is 1 when the block is idle. While the block is armed and waiting, `cfg_ready` is 1 only for address 2. During the countdown and the select cycle, `cfg_ready` is 0. A write offered while `cfg_ready` is 0 is not taken.
- R6: Let edge 1 be the first clock edge at which `trig_in` is sampled high after being low, while the block is armed. With a countdown value N and 2 synchroniser stages, `glitch_sel` is high in the cycle after edge N+4 and in no cycle before it.
- R7: `glitch_sel` stays high for exactly one cycle. `armed` falls at the same edge at which `glitch_sel` falls.
- R8: Trigger rising edges are ignored when the block is not armed and while a countdown or select cycle is in progress. A trigger that is already high when the block is armed produces no glitch until it has gone low and risen again.
- R9: `code_rise` and `code_fall` do not change from the cycle the block is armed until the glitch has completed.
- R10: A write of 0 in data bit 0 to address 2 while the block is armed and waiting disarms it, so `armed` is 0 in the next cycle and no glitch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Trigger from the target device, asynchronous |
| cfg_valid | input | 1 | Write request valid |
| cfg_ready | output | 1 | Write request accepted at this edge when valid |
| cfg_addr | input | 2 | Register address: 0 countdown, 1 step count, 2 arm |
| cfg_data | input | 9 | Write data |
| glitch_sel | output | 1 | Selects the shortened clock for one reference cycle |
| armed | output | 1 | High from arm until the glitch completes or a disarm |
| code_rise | output | 9 | Delay code for the phase giving the rising edge |
| code_fall | output | 9 | Delay code for the phase giving the falling edge |

## Verification
A wrong countdown or sequencer state shows as a select pulse one or more cycles away from edge N+4, or as a pulse that is missing, doubled or too wide. The reference model catches such an error in the very cycle the pulse should rise or fall. A wrong state in the write path shows as a `cfg_ready` value that differs from the model on the next compared cycle. It can also show as a delay code that moves while the block is armed, visible on the cycle after the illegal update. A lost edge-detect state shows as an extra glitch when the trigger is held high across an arm.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_FIRE  = 2'd3
  } seq_state_t;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STEP  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_ARM   = 2'd2;
endpackage

// File: rtl/cgs_trig_sync.sv
module cgs_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic trig_rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= trig_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], trig_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign trig_rise = chain_q[STAGES-1] & ~last_q;

  // R8: an edge detector never reports two rises back to back
  p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise);
endmodule

// File: rtl/cgs_cfg_regs.sv
module cgs_cfg_regs
  import cgs_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int STEP_W   = 9,
  parameter int DATA_W   = 9,
  parameter int MAX_STEP = 285
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  output logic [CNT_W-1:0]  count_val,
  output logic [STEP_W-1:0] step_val,
  output logic              arm_set,
  output logic              arm_clr
);
  localparam logic [STEP_W-1:0] STEP_LIMIT = STEP_W'(MAX_STEP);

  logic              take;
  logic [STEP_W-1:0] step_raw;
  logic [STEP_W-1:0] step_clamped;

  always_comb begin
    unique case (state)
      ST_IDLE:  cfg_ready = 1'b1;
      ST_ARMED: cfg_ready = (cfg_addr == ADDR_ARM);
      default:  cfg_ready = 1'b0;
    endcase
  end

  assign take         = cfg_valid & cfg_ready;
  assign step_raw     = cfg_data[STEP_W-1:0];
  assign step_clamped = (step_raw > STEP_LIMIT) ? STEP_LIMIT : step_raw;
  assign arm_set      = take & (cfg_addr == ADDR_ARM) &  cfg_data[0];
  assign arm_clr      = take & (cfg_addr == ADDR_ARM) & ~cfg_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_val <= '0;
      step_val  <= '0;
    end else if (take) begin
      if (cfg_addr == ADDR_COUNT) count_val <= cfg_data[CNT_W-1:0];
      if (cfg_addr == ADDR_STEP)  step_val  <= step_clamped;
    end
  end

  // R3: the stored step never reaches a full period
  p_step_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_val <= STEP_LIMIT);
  // R9: settings are frozen whenever the sequencer is not idle
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(step_val) && $stable(count_val)));
endmodule

// File: rtl/cgs_sequencer.sv
module cgs_sequencer
  import cgs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_set,
  input  logic             arm_clr,
  input  logic             trig_rise,
  input  logic [CNT_W-1:0] count_val,
  output seq_state_t       state,
  output logic             glitch_sel,
  output logic             armed
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (arm_set) state <= ST_ARMED;
        ST_ARMED: begin
          if (arm_clr) begin
            state <= ST_IDLE;
          end else if (trig_rise) begin
            state    <= ST_COUNT;
            remain_q <= count_val;
          end
        end
        ST_COUNT: begin
          if (remain_q == '0) state    <= ST_FIRE;
          else                remain_q <= remain_q - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign glitch_sel = (state == ST_FIRE);
  assign armed      = (state != ST_IDLE);

  // R7: the select pulse is one reference cycle wide
  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_sel |=> !glitch_sel);
  // R7: the block disarms as the select pulse ends
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glitch_sel) |-> !armed);
  // R10: a disarm while waiting takes effect at once
  p_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_clr && state == ST_ARMED) |=> !armed);
endmodule

// File: rtl/cgs_phase_code.sv
module cgs_phase_code #(
  parameter int STEP_W   = 9,
  parameter bit ROUND_UP = 1'b0
) (
  input  logic [STEP_W-1:0] step_val,
  output logic [STEP_W-1:0] code_rise,
  output logic [STEP_W-1:0] code_fall
);
  assign code_rise = step_val;

  generate
    if (ROUND_UP) begin : g_round
      assign code_fall = (step_val >> 1) + STEP_W'(step_val[0]);
    end else begin : g_trunc
      assign code_fall = step_val >> 1;
    end
  endgenerate
endmodule

// File: rtl/clk_glitch_seq.sv
module clk_glitch_seq
  import cgs_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int STEP_W      = 9,
  parameter int MAX_STEP    = 285,
  parameter int SYNC_STAGES = 2,
  parameter bit ROUND_UP    = 1'b0,
  localparam int DATA_W     = (CNT_W > STEP_W) ? CNT_W : STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              glitch_sel,
  output logic              armed,
  output logic [STEP_W-1:0] code_rise,
  output logic [STEP_W-1:0] code_fall
);
  seq_state_t        state;
  logic              trig_rise;
  logic              arm_set;
  logic              arm_clr;
  logic [CNT_W-1:0]  count_val;
  logic [STEP_W-1:0] step_val;

  cgs_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_rise(trig_rise)
  );

  cgs_cfg_regs #(
    .CNT_W(CNT_W), .STEP_W(STEP_W), .DATA_W(DATA_W), .MAX_STEP(MAX_STEP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .state(state),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .count_val(count_val), .step_val(step_val),
    .arm_set(arm_set), .arm_clr(arm_clr)
  );

  cgs_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .arm_clr(arm_clr),
    .trig_rise(trig_rise), .count_val(count_val), .state(state),
    .glitch_sel(glitch_sel), .armed(armed)
  );

  cgs_phase_code #(.STEP_W(STEP_W), .ROUND_UP(ROUND_UP)) u_code (
    .step_val(step_val), .code_rise(code_rise), .code_fall(code_fall)
  );

  // R5: no write is accepted while the select cycle is running
  p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_sel |-> !cfg_ready);
  // R9: delay codes hold while armed
  p_codes_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> ($stable(code_rise) && $stable(code_fall)));
endmodule

// File: tb/clk_glitch_seq_bench.sv
module clk_glitch_seq_bench;
  localparam int S    = 2;
  localparam int MAXS = 285;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_in = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_ready;
  logic [1:0] cfg_addr = 2'd0;
  logic [8:0] cfg_data = 9'd0;
  logic       glitch_sel, armed;
  logic [8:0] code_rise, code_fall;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clk_glitch_seq u_clk_glitch_seq (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .glitch_sel(glitch_sel), .armed(armed),
    .code_rise(code_rise), .code_fall(code_fall)
  );

  // behavioural reference model: 0 idle, 1 waiting, 2 counting, 3 select
  int m_state = 0, m_left = 0, m_cd = 0, m_step = 0;
  int m_hist[$];
  int m_last = 0;

  function automatic int m_ready();
    if (m_state == 0) return 1;
    if (m_state == 1) return (cfg_addr == 2'd2) ? 1 : 0;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_left = 0; m_cd = 0; m_step = 0; m_last = 0;
      m_hist = {};
      for (int i = 0; i < S; i++) m_hist.push_back(0);
    end else begin
      int rise, acc, d;
      rise = (m_hist[S-1] == 1 && m_last == 0) ? 1 : 0;
      acc  = (cfg_valid && m_ready() == 1) ? 1 : 0;
      d    = int'(cfg_data);
      m_last = m_hist[S-1];
      void'(m_hist.pop_back());
      m_hist.push_front(int'(trig_in));
      case (m_state)
        0: if (acc == 1) begin
             if (cfg_addr == 2'd0) m_cd = d % 256;
             if (cfg_addr == 2'd1) m_step = (d > MAXS) ? MAXS : d;
             if (cfg_addr == 2'd2 && d % 2 == 1) m_state = 1;
           end
        1: if (acc == 1 && d % 2 == 0) m_state = 0;
           else if (rise == 1) begin m_state = 2; m_left = m_cd; end
        2: if (m_left == 0) m_state = 3; else m_left = m_left - 1;
        default: m_state = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R6", "glitch_sel", int'(glitch_sel), (m_state == 3) ? 1 : 0);
    chk("R7", "armed", int'(armed), (m_state != 0) ? 1 : 0);
    chk("R3", "code_rise", int'(code_rise), m_step);
    chk("R4", "code_fall", int'(code_fall), m_step / 2);
    chk("R5", "cfg_ready", int'(cfg_ready), m_ready());
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    compare_all();
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    cfg_valid = 1'b1; cfg_addr = a; cfg_data = 9'(d);
    tick();
    cfg_valid = 1'b0;
  endtask

  task automatic run_glitch(input int n, input string req);
    int seen;
    wr(2'd0, n);
    wr(2'd2, 1);
    trig_in = 1'b1;
    seen = 0;
    for (int k = 1; k <= n + S + 8; k++) begin
      tick();
      if (k == 1) trig_in = 1'b0;
      if (k == 3) trig_in = 1'b1;   // extra rise during countdown, ignored (R8)
      if (k == 4) trig_in = 1'b0;
      if (glitch_sel && seen == 0) begin
        seen = k;
        chk(req, "select latency", k, n + S + 2);
      end
    end
    chk(req, "glitch observed", (seen != 0) ? 1 : 0, 1);
    chk("R7", "disarmed after glitch", int'(armed), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int sel_cnt;
    #1;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", "sel at reset", int'(glitch_sel), 0);
    chk("R1", "armed at reset", int'(armed), 0);
    chk("R1", "code_rise at reset", int'(code_rise), 0);
    chk("R1", "ready at reset", int'(cfg_ready), 1);
    rst_n = 1'b1;
    tick();

    // R2/R4: step write shows on codes
    wr(2'd1, 100);
    chk("R2", "step write", int'(code_rise), 100);
    chk("R4", "half code", int'(code_fall), 50);
    wr(2'd1, 7);
    chk("R4", "odd half code", int'(code_fall), 3);
    // R3: clamp
    wr(2'd1, 400);
    chk("R3", "clamp 400", int'(code_rise), MAXS);
    wr(2'd1, 511);
    chk("R3", "clamp 511", int'(code_fall), MAXS / 2);
    wr(2'd1, 285);
    chk("R3", "exact limit", int'(code_rise), 285);
    wr(2'd3, 9);
    chk("R2", "address 3 ignored", int'(code_rise), 285);

    // R8: trigger while idle is ignored
    wr(2'd1, 120);
    trig_in = 1'b1; tick(); trig_in = 1'b0;
    sel_cnt = 0;
    for (int k = 0; k < 10; k++) begin tick(); if (glitch_sel) sel_cnt++; end
    chk("R8", "idle trigger ignored", sel_cnt, 0);

    // R5/R9: write stalled while armed
    wr(2'd2, 1);
    cfg_valid = 1'b1; cfg_addr = 2'd1; cfg_data = 9'd33;
    for (int k = 0; k < 4; k++) tick();
    chk("R5", "ready low for step while armed", int'(cfg_ready), 0);
    chk("R9", "code held while armed", int'(code_rise), 120);
    cfg_valid = 1'b0;
    // R10: disarm
    wr(2'd2, 0);
    chk("R10", "disarmed", int'(armed), 0);
    trig_in = 1'b1; tick(); trig_in = 1'b0;
    sel_cnt = 0;
    for (int k = 0; k < 10; k++) begin tick(); if (glitch_sel) sel_cnt++; end
    chk("R10", "no glitch after disarm", sel_cnt, 0);

    // R6: latency for several countdowns
    run_glitch(5, "R6");
    run_glitch(0, "R6");
    run_glitch(1, "R6");
    run_glitch(9, "R6");

    // R8: trigger held high across arm gives no glitch until a new rise
    trig_in = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    wr(2'd0, 2);
    wr(2'd2, 1);
    sel_cnt = 0;
    for (int k = 0; k < 15; k++) begin tick(); if (glitch_sel) sel_cnt++; end
    chk("R8", "held trigger no glitch", sel_cnt, 0);
    chk("R8", "still armed", int'(armed), 1);
    trig_in = 1'b0; tick(); tick();
    trig_in = 1'b1;
    sel_cnt = 0;
    for (int k = 0; k < 15; k++) begin tick(); if (glitch_sel) sel_cnt++; end
    chk("R8", "one glitch after new rise", sel_cnt, 1);
    trig_in = 1'b0;

    // campaign sweep across the clamp boundary
    for (int st = 282; st <= 288; st++) begin
      wr(2'd1, st);
      chk("R3", "sweep code", int'(code_rise), (st > MAXS) ? MAXS : st);
      run_glitch(3, "R6");
    end

    for (int k = 0; k < 5; k++) tick();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule